// File: doc/BRIEF.md
# Chunked CRC-16 Bloom Key Hasher

This block turns a wide lookup key into a 16-bit Bloom filter index. The key is given as a packed byte vector holding up to twelve 36-bit key blocks. A 4-bit mask identifier and a 12-bit region identifier come with it. On a start strobe the block captures its inputs. It then builds between one and three 23-byte chunks. Each chunk has three zero bytes, then a big-endian identifier word, then eighteen key bytes. The block feeds the chunk bytes one per clock into a CRC-16 with polynomial 0x8529.

A single-cycle done pulse marks the result. The hash output keeps its value until the next result is ready. Callers use the hash to pick which filter bit to set, clear or test. They can stream requests back to back: the block accepts a new start in any cycle in which it is not hashing, including the cycle of the done pulse.

Top module: `bloom_key_hasher`

## Requirements
- R1: The hash is a CRC-16 with polynomial 0x8529, processed most significant bit first. It starts from 0 and has no final XOR. Each byte updates the CRC as crc = (crc << 8) ^ T[(crc >> 8) ^ byte], where T[x] is the CRC of the single byte x. Two examples: T[0x01] = 0x8529 and T[0xFF] = 0x9DC1.
- R2: Every chunk is 23 bytes long. Bytes 0 to 2 are zero. Bytes 3 and 4 are the identifier word. Bytes 5 to 22 are eighteen key bytes, in ascending order of key byte.
- R3: The identifier word is {region_id_i, mask_id_i}, with the mask in bits 3:0. Its high byte is hashed first (chunk byte 3) and its low byte second (chunk byte 4).
- R4: The block count sets the chunk count. A count of 1 to 4 gives one chunk, 5 to 8 gives two chunks, and 9 to 12 gives three chunks. A count of 0 is treated as one chunk, and a count of 13 to 15 as three chunks.
- R5: Only the highest-numbered chunks are hashed. Hashing runs from chunk index 3 − chunk_count up to chunk 2. The key bytes of chunk c are key_i bytes 2+18c to 19+18c, where key byte n is key_i[8n+7:8n].
- R6: After the clock edge that samples start_i, done_o rises 23 × chunk_count clock edges later (23, 46 or 69).
- R7: done_o stays high for exactly one cycle.
- R8: A start_i that arrives while a hash is in progress is ignored. The running hash keeps its original inputs and its latency, and no extra done pulse follows.
- R9: hash_o changes only in the cycle in which done_o is high, and it holds its value until the next result.
- R10: While reset is asserted (rst_n low), done_o and hash_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe. Sampled only when idle |
| key_i | input | 448 | Packed encoded key. Byte n is bits 8n+7:8n |
| block_cnt_i | input | 4 | Number of key blocks in use |
| mask_id_i | input | 4 | Mask identifier |
| region_id_i | input | 12 | Region identifier |
| done_o | output | 1 | One-cycle pulse when the hash is ready |
| hash_o | output | 16 | Bloom filter index. Held until the next result |

## Verification
A wrong byte counter or chunk counter shows up at the ports in two ways. The done pulse lands on the wrong cycle, measured from the start edge, so latency checks for every chunk count expose it on the first request. Selecting the wrong key byte or identifier byte, or using a wrong CRC step, leaves the timing correct but corrupts hash_o when done rises. The bench compares that value against an independent table-driven model over directed block counts and random keys. A start that is wrongly accepted while busy would show as a changed hash or an early done on the same request.

// File: rtl/bkh_pkg.sv
package bkh_pkg;
    localparam int HASH_W           = 16;
    localparam int MASK_W           = 4;
    localparam int REGION_W         = 12;
    localparam int ID_W             = MASK_W + REGION_W;
    localparam int PAD_BYTES        = 3;
    localparam int ID_BYTES         = ID_W / 8;
    localparam int HDR_BYTES        = PAD_BYTES + ID_BYTES;
    localparam int BLOCK_BYTES      = 18;
    localparam int CHUNK_BYTES      = HDR_BYTES + BLOCK_BYTES;
    localparam int MAX_CHUNKS       = 3;
    localparam int BLOCKS_PER_CHUNK = 4;
    localparam int KEY_OFS          = 2;
    localparam int KEY_BYTES        = KEY_OFS + MAX_CHUNKS * BLOCK_BYTES;
    localparam int KEY_W            = KEY_BYTES * 8;
    localparam int CNT_W            = 4;
    localparam int POS_W            = $clog2(CHUNK_BYTES);
    localparam int CHK_W            = $clog2(MAX_CHUNKS + 1);
    localparam int IDX_W            = $clog2(KEY_BYTES) + 1;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [CHK_W-1:0] chunk_t;

    typedef struct packed {
        logic              busy;
        chunk_t            chunk;
        pos_t              pos;
        logic [HASH_W-1:0] crc;
        logic [ID_W-1:0]   id;
        logic [KEY_W-1:0]  key;
        logic              done;
        logic [HASH_W-1:0] hash;
    } hasher_state_t;
endpackage

// File: rtl/bkh_chunk_span.sv
module bkh_chunk_span
    import bkh_pkg::*;
(
    input  logic [CNT_W-1:0] block_cnt_i,
    output chunk_t           first_chunk_o
);
    logic [CNT_W-1:0] used_d;
    logic [CNT_W-1:0] chunks_d;

    always_comb begin
        used_d = (block_cnt_i == '0) ? CNT_W'(1) : block_cnt_i;
        chunks_d = CNT_W'((used_d - CNT_W'(1)) / CNT_W'(BLOCKS_PER_CHUNK)) + CNT_W'(1);
        if (chunks_d > CNT_W'(MAX_CHUNKS)) begin
            chunks_d = CNT_W'(MAX_CHUNKS);
        end
        first_chunk_o = chunk_t'(CNT_W'(MAX_CHUNKS) - chunks_d);
    end
endmodule

// File: rtl/bkh_byte_mux.sv
module bkh_byte_mux
    import bkh_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    input  logic [ID_W-1:0]  id_i,
    input  chunk_t           chunk_i,
    input  pos_t             pos_i,
    output logic [7:0]       byte_o
);
    logic [IDX_W-1:0] idx_d;
    logic [KEY_W-1:0] shifted_d;

    always_comb begin
        idx_d = IDX_W'(KEY_OFS) + IDX_W'(BLOCK_BYTES) * IDX_W'(chunk_i)
              + IDX_W'(pos_i) - IDX_W'(HDR_BYTES);
        shifted_d = key_i >> {idx_d, 3'b000};
        if (pos_i < pos_t'(PAD_BYTES)) begin
            byte_o = 8'h00;
        end else if (pos_i == pos_t'(PAD_BYTES)) begin
            byte_o = id_i[ID_W-1 -: 8];
        end else if (pos_i < pos_t'(HDR_BYTES)) begin
            byte_o = id_i[7:0];
        end else begin
            byte_o = shifted_d[7:0];
        end
    end
endmodule

// File: rtl/bkh_crc_step.sv
module bkh_crc_step
    import bkh_pkg::*;
#(
    parameter logic [HASH_W-1:0] POLY = 16'h8529
) (
    input  logic [HASH_W-1:0] crc_i,
    input  logic [7:0]        byte_i,
    output logic [HASH_W-1:0] crc_o
);
    logic [HASH_W-1:0] stage [0:8];

    assign stage[0] = crc_i ^ {byte_i, {(HASH_W-8){1'b0}}};

    for (genvar g = 0; g < 8; g++) begin : g_bit
        assign stage[g+1] = stage[g][HASH_W-1]
                          ? ({stage[g][HASH_W-2:0], 1'b0} ^ POLY)
                          :  {stage[g][HASH_W-2:0], 1'b0};
    end

    assign crc_o = stage[8];
endmodule

// File: rtl/bloom_key_hasher.sv
module bloom_key_hasher
    import bkh_pkg::*;
#(
    parameter logic [HASH_W-1:0] POLY = 16'h8529
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [KEY_W-1:0]    key_i,
    input  logic [CNT_W-1:0]    block_cnt_i,
    input  logic [MASK_W-1:0]   mask_id_i,
    input  logic [REGION_W-1:0] region_id_i,
    output logic                done_o,
    output logic [HASH_W-1:0]   hash_o
);
    hasher_state_t     s_d, s_q;
    chunk_t            first_chunk;
    logic [7:0]        cur_byte;
    logic [HASH_W-1:0] crc_next;
    logic              last_byte;

    bkh_chunk_span u_span (
        .block_cnt_i   (block_cnt_i),
        .first_chunk_o (first_chunk)
    );

    bkh_byte_mux u_mux (
        .key_i   (s_q.key),
        .id_i    (s_q.id),
        .chunk_i (s_q.chunk),
        .pos_i   (s_q.pos),
        .byte_o  (cur_byte)
    );

    bkh_crc_step #(.POLY(POLY)) u_crc (
        .crc_i  (s_q.crc),
        .byte_i (cur_byte),
        .crc_o  (crc_next)
    );

    assign last_byte = (s_q.pos == pos_t'(CHUNK_BYTES - 1))
                    && (s_q.chunk == chunk_t'(MAX_CHUNKS - 1));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.chunk = first_chunk;
                s_d.pos   = '0;
                s_d.crc   = '0;
                s_d.id    = {region_id_i, mask_id_i};
                s_d.key   = key_i;
            end
        end else begin
            s_d.crc = crc_next;
            if (s_q.pos == pos_t'(CHUNK_BYTES - 1)) begin
                s_d.pos = '0;
                if (last_byte) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.hash = crc_next;
                end else begin
                    s_d.chunk = s_q.chunk + chunk_t'(1);
                end
            end else begin
                s_d.pos = s_q.pos + pos_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;
    assign hash_o = s_q.hash;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_hash_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(hash_o));

    a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i && !last_byte) |=> (s_q.busy && $stable(s_q.id) && $stable(s_q.key)));

    a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.pos < pos_t'(PAD_BYTES)) |-> (cur_byte == 8'h00));

    a_r3_id_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.pos == pos_t'(PAD_BYTES)) |-> (cur_byte == s_q.id[ID_W-1 -: 8]));

    a_r6_counter_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.pos < pos_t'(CHUNK_BYTES) && s_q.chunk < chunk_t'(MAX_CHUNKS)));

    a_r4_single_chunk_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i && block_cnt_i <= CNT_W'(BLOCKS_PER_CHUNK))
        |=> (s_q.busy && s_q.chunk == chunk_t'(MAX_CHUNKS - 1)));

    a_r1_crc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i) |=> (s_q.crc == '0 && s_q.pos == '0));
endmodule

// File: tb/bloom_key_hasher_bench.sv
module bloom_key_hasher_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [447:0] key_i = '0;
    logic [3:0]   block_cnt_i = '0;
    logic [3:0]   mask_id_i = '0;
    logic [11:0]  region_id_i = '0;
    logic         done_o;
    logic [15:0]  hash_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bloom_key_hasher u_bloom_key_hasher (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .key_i       (key_i),
        .block_cnt_i (block_cnt_i),
        .mask_id_i   (mask_id_i),
        .region_id_i (region_id_i),
        .done_o      (done_o),
        .hash_o      (hash_o)
    );

    function automatic logic [15:0] tab(input logic [7:0] x);
        logic [15:0] r;
        r = {x, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h8529) : (r << 1);
        return r;
    endfunction

    function automatic int n_chunks(input int nb);
        int c;
        c = (nb == 0) ? 1 : ((nb - 1) / 4 + 1);
        if (c > 3) c = 3;
        return c;
    endfunction

    function automatic logic [15:0] ref_hash(input logic [447:0] k, input int nb,
                                             input logic [3:0] m, input logic [11:0] rg);
        logic [15:0] crc;
        logic [15:0] id;
        logic [7:0]  b;
        crc = 16'h0;
        id  = {rg, m};
        for (int c = 3 - n_chunks(nb); c < 3; c++) begin
            for (int p = 0; p < 23; p++) begin
                if (p < 3)       b = 8'h00;
                else if (p == 3) b = id[15:8];
                else if (p == 4) b = id[7:0];
                else             b = k[8*(2 + 18*c + p - 5) +: 8];
                crc = (crc << 8) ^ tab(crc[15:8] ^ b);
            end
        end
        return crc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [447:0] k, input int nb, input logic [3:0] m,
                           input logic [11:0] rg, input bit poke_busy);
        int lat;
        logic [15:0] exp_h;
        exp_h = ref_hash(k, nb, m, rg);
        @(negedge clk);
        key_i = k; block_cnt_i = 4'(nb); mask_id_i = m; region_id_i = rg; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 200) begin
            if (poke_busy && lat == 4) begin
                // R8: a second start with other inputs while busy
                key_i = ~k; block_cnt_i = 4'd12; mask_id_i = ~m; region_id_i = ~rg; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(lat == 23 * n_chunks(nb), "R6 latency", lat, 23 * n_chunks(nb));
        check(hash_o == exp_h, poke_busy ? "R8 hash after ignored start" : "R1/R5 hash", hash_o, exp_h);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done single pulse", done_o, 0);
        repeat (2) @(negedge clk);
        check(hash_o == exp_h, "R9 hash held", hash_o, exp_h);
        if (poke_busy) begin
            bit extra;
            extra = 1'b0;
            repeat (80) begin
                @(negedge clk);
                if (done_o) extra = 1'b1;
            end
            check(!extra, "R8 no extra done", extra, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [447:0] k;
        logic [447:0] k2;
        int dummy;
        dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R10 reset done", done_o, 0);
        check(hash_o == 16'h0, "R10 reset hash", hash_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: bench model table sanity against known values
        check(tab(8'h01) == 16'h8529, "R1 table entry 1", tab(8'h01), 16'h8529);
        check(tab(8'hFF) == 16'h9DC1, "R1 table entry 255", tab(8'hFF), 16'h9DC1);

        // R1: all zero input hashes to zero
        run_one('0, 4, 4'h0, 12'h000, 1'b0);

        for (int w = 0; w < 14; w++) k[32*w +: 32] = $urandom;

        // R4: chunk count boundaries, including 0 and out-of-range counts
        run_one(k, 0,  4'h3, 12'h0A5, 1'b0);
        run_one(k, 1,  4'h1, 12'h123, 1'b0);
        run_one(k, 4,  4'hF, 12'hFFF, 1'b0);
        run_one(k, 5,  4'h7, 12'h800, 1'b0);
        run_one(k, 8,  4'h2, 12'h001, 1'b0);
        run_one(k, 9,  4'h9, 12'h456, 1'b0);
        run_one(k, 12, 4'hC, 12'hABC, 1'b0);
        run_one(k, 15, 4'h5, 12'h777, 1'b0);

        // R5: bytes below chunk 2 have no effect with one chunk
        k2 = k;
        for (int b = 0; b < 38; b++) k2[8*b +: 8] = ~k[8*b +: 8];
        check(ref_hash(k2, 3, 4'h6, 12'h321) == ref_hash(k, 3, 4'h6, 12'h321), "R5 model scope",
              ref_hash(k2, 3, 4'h6, 12'h321), ref_hash(k, 3, 4'h6, 12'h321));
        run_one(k2, 3, 4'h6, 12'h321, 1'b0);

        // R2/R3: mask and region bits distinguish results
        run_one(k, 2, 4'h8, 12'h000, 1'b0);
        run_one(k, 2, 4'h0, 12'h010, 1'b0);

        // R8: start while busy
        run_one(k, 6, 4'hA, 12'h5A5, 1'b1);

        // random mix
        for (int t = 0; t < 40; t++) begin
            for (int w = 0; w < 14; w++) k[32*w +: 32] = $urandom;
            run_one(k, int'($urandom_range(0, 15)), 4'($urandom), 12'($urandom), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule